// File: doc/BRIEF.md
# Sleep and Interrupt-Enable Instruction Unit

This block sits beside a 32-bit integer pipeline and handles three custom instructions. A sleep instruction stops issue until an interrupt request line goes high. A get-enable instruction copies the global interrupt-enable flag into a general register. A set-enable instruction loads that flag from a general register. The unit owns the single enable flag and reports it on `irq_en_o` so that the interrupt logic around it can use it.

The pipeline presents each issued word on `instr_i`, qualified by `instr_vld_i`. It also presents the value of the register named in bits 15:11 of the word on `rt_data_i`. The unit accepts an instruction only while it is not stalling. The get-enable result comes back one cycle after acceptance, on a register write port (`rf_we_o`, `rf_idx_o`, `rf_wdata_o`).

Two states are held in `irq_wait_fsm`:
- RUN: issue proceeds. An accepted sleep word takes RUN→SLEEP at the next edge.
- SLEEP: `stall_o` is high while every request line is low. In the first cycle that any line is high, `stall_o` drops at once and the state takes SLEEP→RUN at the next edge. The enable flag plays no part in this wake-up.

Top module: `irq_ctl_unit`

## Requirements
- R1: Only the exact word 0x70000000 is a sleep instruction. Once it is accepted, `stall_o` is high from the next cycle. A word that differs in any bit, for example 0x70000001, does not stall.
- R2: While asleep and with all `irq_req_i` lines low, `stall_o` stays high for as long as the lines stay low, whatever value the enable flag holds.
- R3: In the first cycle in which any `irq_req_i` line is high while asleep, `stall_o` is low in that same cycle. The unit is running again from the next cycle.
- R4: Get-enable matches when (instr & 0xFFFF07FF) == 0x70000024. The target register index is instr[15:11]. One cycle after acceptance, `rf_we_o`=1, `rf_idx_o` holds that index and `rf_wdata_o` holds the flag as it was at acceptance, zero-extended to 32 bits.
- R5: Set-enable matches when (instr & 0xFFFF07FF) == 0x70000026. It loads bit 0 of `rt_data_i` into the flag, and the new value appears on `irq_en_o` in the next cycle. The other bits of `rt_data_i` are ignored.
- R6: A get-enable whose index field is 0 raises no `rf_we_o`.
- R7: A word that matches none of the three patterns raises no `rf_we_o` and leaves the flag and the run state unchanged. This includes words that differ from a pattern only in masked-in bits such as bit 24, bit 16 or bit 10.
- R8: After reset the flag is 0, `stall_o` is 0 and `rf_we_o` is 0.
- R9: A word presented with `instr_vld_i` low has no effect.
- R10: Words presented while `stall_o` is high are not accepted. The flag is unchanged and no write is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 32 | Issued instruction word |
| instr_vld_i | input | 1 | Qualifies `instr_i` |
| rt_data_i | input | 32 | Value of the register named by instr[15:11] |
| irq_req_i | input | 8 | Pending interrupt request lines |
| stall_o | output | 1 | Holds issue while asleep |
| rf_we_o | output | 1 | Register write enable |
| rf_idx_o | output | 5 | Register write index |
| rf_wdata_o | output | 32 | Register write data |
| irq_en_o | output | 1 | Global interrupt-enable flag |

## Verification
The hardest case to reach is an instruction presented while the unit sleeps, together with the wake-up cycle that follows it. The instruction must be dropped, and the release must be combinational in the very cycle a request line rises. The bench first puts the unit to sleep with the flag both clear and set. It then drives a valid set-enable word during the sleep and checks that the flag has not moved. Finally it raises a single request line mid-cycle and samples `stall_o` before the next edge.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
    localparam logic [31:0] SLEEP_WORD  = 32'h7000_0000;
    localparam logic [31:0] STATE_MASK  = 32'hFFFF_07FF;
    localparam logic [31:0] GET_PATTERN = 32'h7000_0024;
    localparam logic [31:0] SET_PATTERN = 32'h7000_0026;
    localparam int unsigned IDX_LSB     = 11;

    typedef enum logic {
        WAIT_RUN   = 1'b0,
        WAIT_SLEEP = 1'b1
    } wait_state_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_SLEEP = 2'd1,
        OP_GET   = 2'd2,
        OP_SET   = 2'd3
    } op_e;
endpackage

// File: rtl/irq_op_decode.sv
module irq_op_decode
    import irq_ctl_pkg::*;
#(
    parameter int unsigned INSTR_W   = 32,
    parameter int unsigned REG_IDX_W = 5
) (
    input  logic [INSTR_W-1:0]   instr_i,
    input  logic                 vld_i,
    input  logic                 accept_i,
    output op_e                  op_o,
    output logic [REG_IDX_W-1:0] idx_o
);
    logic take;

    always_comb begin
        take  = vld_i && accept_i;
        idx_o = instr_i[IDX_LSB +: REG_IDX_W];
        op_o  = OP_NONE;
        if (take) begin
            if (instr_i == SLEEP_WORD)
                op_o = OP_SLEEP;
            else if ((instr_i & STATE_MASK) == GET_PATTERN)
                op_o = OP_GET;
            else if ((instr_i & STATE_MASK) == SET_PATTERN)
                op_o = OP_SET;
        end
    end
endmodule

// File: rtl/irq_wait_fsm.sv
module irq_wait_fsm
    import irq_ctl_pkg::*;
#(
    parameter int unsigned NIRQ = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sleep_req_i,
    input  logic [NIRQ-1:0] irq_req_i,
    output logic            stall_o,
    output logic            asleep_o
);
    wait_state_e state_q, state_d;
    logic        wake;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WAIT_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        wake    = |irq_req_i;
        state_d = state_q;
        unique case (state_q)
            WAIT_RUN:   if (sleep_req_i) state_d = WAIT_SLEEP;
            WAIT_SLEEP: if (wake)        state_d = sleep_req_i ? WAIT_SLEEP : WAIT_RUN;
            default:                     state_d = WAIT_RUN;
        endcase
    end

    always_comb begin
        stall_o  = 1'b0;
        asleep_o = 1'b0;
        unique case (state_q)
            WAIT_RUN:   stall_o = 1'b0;
            WAIT_SLEEP: begin
                asleep_o = 1'b1;
                stall_o  = !wake;
            end
            default:    stall_o = 1'b0;
        endcase
    end

    // R3: a raised request line ends the sleep unless a new sleep is taken
    a_r3_wake_leaves_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WAIT_SLEEP && (|irq_req_i) && !sleep_req_i) |=> state_q == WAIT_RUN);
    // R2: with no request, the sleep persists
    a_r2_hold_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WAIT_SLEEP && !(|irq_req_i)) |=> state_q == WAIT_SLEEP);
endmodule

// File: rtl/irq_state_reg.sv
module irq_state_reg
    import irq_ctl_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned REG_IDX_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  op_e                  op_i,
    input  logic [REG_IDX_W-1:0] idx_i,
    input  logic [DATA_W-1:0]    rt_data_i,
    output logic                 en_o,
    output logic                 rf_we_o,
    output logic [REG_IDX_W-1:0] rf_idx_o,
    output logic [DATA_W-1:0]    rf_wdata_o
);
    localparam logic [REG_IDX_W-1:0] ZERO_IDX = '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o       <= 1'b0;
            rf_we_o    <= 1'b0;
            rf_idx_o   <= '0;
            rf_wdata_o <= '0;
        end else begin
            rf_we_o <= 1'b0;
            if (op_i == OP_SET)
                en_o <= rt_data_i[0];
            if (op_i == OP_GET && idx_i != ZERO_IDX) begin
                rf_we_o    <= 1'b1;
                rf_idx_o   <= idx_i;
                rf_wdata_o <= {{(DATA_W-1){1'b0}}, en_o};
            end
        end
    end

    // R5: a set loads bit 0 of the operand
    a_r5_set_loads_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SET) |=> en_o == $past(rt_data_i[0]));
    // R4: written value is zero-extended
    a_r4_zero_extend: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> rf_wdata_o[DATA_W-1:1] == '0);
    // R6: register 0 is never written
    a_r6_no_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> rf_idx_o != ZERO_IDX);
endmodule

// File: rtl/irq_ctl_unit.sv
module irq_ctl_unit
    import irq_ctl_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned REG_IDX_W = 5,
    parameter int unsigned NIRQ      = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [31:0]          instr_i,
    input  logic                 instr_vld_i,
    input  logic [DATA_W-1:0]    rt_data_i,
    input  logic [NIRQ-1:0]      irq_req_i,
    output logic                 stall_o,
    output logic                 rf_we_o,
    output logic [REG_IDX_W-1:0] rf_idx_o,
    output logic [DATA_W-1:0]    rf_wdata_o,
    output logic                 irq_en_o
);
    op_e                  op;
    logic [REG_IDX_W-1:0] idx;
    logic                 asleep;
    logic                 stall;

    irq_op_decode #(.INSTR_W(32), .REG_IDX_W(REG_IDX_W)) u_dec (
        .instr_i  (instr_i),
        .vld_i    (instr_vld_i),
        .accept_i (!stall),
        .op_o     (op),
        .idx_o    (idx)
    );

    irq_wait_fsm #(.NIRQ(NIRQ)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_req_i (op == OP_SLEEP),
        .irq_req_i   (irq_req_i),
        .stall_o     (stall),
        .asleep_o    (asleep)
    );

    irq_state_reg #(.DATA_W(DATA_W), .REG_IDX_W(REG_IDX_W)) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_i       (op),
        .idx_i      (idx),
        .rt_data_i  (rt_data_i),
        .en_o       (irq_en_o),
        .rf_we_o    (rf_we_o),
        .rf_idx_o   (rf_idx_o),
        .rf_wdata_o (rf_wdata_o)
    );

    assign stall_o = stall;

    // R10: while stalled, the flag holds and nothing is written
    a_r10_stalled_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (irq_en_o == $past(irq_en_o)) && !rf_we_o);
    // R1: an accepted sleep word stalls next cycle unless a request is up
    a_r1_sleep_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_vld_i && !stall && instr_i == SLEEP_WORD) |=> asleep);
    // R3: stall never coexists with a raised request line
    a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_req_i) |-> !stall_o);
endmodule

// File: tb/tb_irq_ctl_unit.sv
module tb_irq_ctl_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] instr;
    logic        vld;
    logic [31:0] rt;
    logic [7:0]  irq;
    logic        stall, we, en;
    logic [4:0]  idx;
    logic [31:0] wdata;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    irq_ctl_unit dut (
        .clk(clk), .rst_n(rst_n), .instr_i(instr), .instr_vld_i(vld),
        .rt_data_i(rt), .irq_req_i(irq), .stall_o(stall), .rf_we_o(we),
        .rf_idx_o(idx), .rf_wdata_o(wdata), .irq_en_o(en)
    );

    typedef struct packed {
        logic [31:0] instr;
        logic [31:0] rt;
        logic        we;
        logic [4:0]  idx;
        logic [31:0] data;
        logic        en;
    } vec_t;

    localparam vec_t TBL [12] = '{
        '{32'h7000_2824, 32'h0,         1'b1, 5'd5,  32'd0, 1'b0}, // R4 get rd5
        '{32'h7000_1826, 32'h1,         1'b0, 5'd0,  32'd0, 1'b1}, // R5 set 1
        '{32'h7000_F824, 32'h0,         1'b1, 5'd31, 32'd1, 1'b1}, // R4 get rd31
        '{32'h7000_0026, 32'hFFFF_FFFE, 1'b0, 5'd0,  32'd0, 1'b0}, // R5 bit0 only
        '{32'h7000_3824, 32'h0,         1'b1, 5'd7,  32'd0, 1'b0}, // R4 get rd7
        '{32'h7000_0826, 32'h3,         1'b0, 5'd0,  32'd0, 1'b1}, // R5 set 1
        '{32'h7000_0024, 32'h0,         1'b0, 5'd0,  32'd0, 1'b1}, // R6 rd0
        '{32'h7000_0025, 32'h0,         1'b0, 5'd0,  32'd0, 1'b1}, // R7
        '{32'h7100_0026, 32'h0,         1'b0, 5'd0,  32'd0, 1'b1}, // R7 bit24
        '{32'h7001_0026, 32'h0,         1'b0, 5'd0,  32'd0, 1'b1}, // R7 bit16
        '{32'h7000_0426, 32'h0,         1'b0, 5'd0,  32'd0, 1'b1}, // R7 bit10
        '{32'h7000_F826, 32'h0,         1'b0, 5'd0,  32'd0, 1'b0}  // R5 set 0
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] w, input logic [31:0] r, input logic v);
        @(negedge clk);
        instr = w; rt = r; vld = v;
        @(negedge clk);
        vld = 1'b0; instr = 32'h0;
    endtask

    initial begin
        #500000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; instr = '0; vld = 1'b0; rt = '0; irq = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 en", {31'b0, en}, 32'd0);
        chk("R8 stall", {31'b0, stall}, 32'd0);
        chk("R8 we", {31'b0, we}, 32'd0);

        // R9: invalid word has no effect
        issue(32'h7000_0026, 32'h1, 1'b0);
        chk("R9 en", {31'b0, en}, 32'd0);

        for (int i = 0; i < 12; i++) begin
            issue(TBL[i].instr, TBL[i].rt, 1'b1);
            chk("R4/R5/R6/R7 we", {31'b0, we}, {31'b0, TBL[i].we});
            if (TBL[i].we) begin
                chk("R4 idx", {27'b0, idx}, {27'b0, TBL[i].idx});
                chk("R4 data", wdata, TBL[i].data);
            end
            chk("R5/R7 en", {31'b0, en}, {31'b0, TBL[i].en});
            chk("R7 stall", {31'b0, stall}, 32'd0);
        end

        // R1: near-miss word does not stall
        issue(32'h7000_0001, 32'h0, 1'b1);
        chk("R1 near miss", {31'b0, stall}, 32'd0);

        // R1/R2: sleep with flag clear
        issue(32'h7000_0000, 32'h0, 1'b1);
        chk("R1 stall", {31'b0, stall}, 32'd1);
        // R10: set-enable while asleep is dropped
        issue(32'h7000_0026, 32'h1, 1'b1);
        chk("R10 en", {31'b0, en}, 32'd0);
        chk("R10 we", {31'b0, we}, 32'd0);
        repeat (5) @(negedge clk);
        chk("R2 hold", {31'b0, stall}, 32'd1);
        // R3: raise one line mid-cycle
        irq = 8'h04;
        #1;
        chk("R3 same cycle", {31'b0, stall}, 32'd0);
        @(negedge clk);
        irq = 8'h00;
        #1;
        chk("R3 running", {31'b0, stall}, 32'd0);

        // R2: sleep with flag set
        issue(32'h7000_0026, 32'h1, 1'b1);
        chk("R5 en", {31'b0, en}, 32'd1);
        issue(32'h7000_0000, 32'h0, 1'b1);
        repeat (3) @(negedge clk);
        chk("R2 flag set", {31'b0, stall}, 32'd1);
        irq = 8'h80;
        #1;
        chk("R3 top line", {31'b0, stall}, 32'd0);
        @(negedge clk);
        irq = 8'h00;
        @(negedge clk);
        chk("R3 after", {31'b0, stall}, 32'd0);

        // R8: reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R8 en after reset", {31'b0, en}, 32'd0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule